// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the instruction fetch address for a small controller whose instructions are 12 bits wide. It holds a program counter of 9, 10 or 11 bits, set by a parameter, which covers 512, 1K or 2K words of program memory. Each cycle the counter either steps to the next word or loads a branch target. A target comes from the instruction's immediate field, from a write to the counter's low byte, or from a two-entry return stack.

Program memory is divided into 512-word pages. For jumps, subroutine calls and low-byte writes, the address bits above bit 8 come from page-select bits held in a status register. After reset the counter holds all ones, so the first fetch is from the highest address. Every taken branch raises a flush signal for one cycle. In that cycle the prefetched instruction is discarded, and any control strobes that arrive are ignored. A return also sends the instruction's 8-bit literal to the working register.

Top module: `paged_pc`

## Requirements
- R1: While `rst` is high at a clock edge, the fetch address becomes all ones and `flush_o` and `w_wr_o` become 0.
- R2: In a cycle with no accepted strobe, the fetch address at the next edge is the current address plus one.
- R3: An accepted jump (`goto_i`) loads `imm_i[8:0]` into address bits 8..0. Address bit 9 is loaded from `stat_i[5]` and bit 10 from `stat_i[6]` when the counter is that wide. `stat_i[7]` and `stat_i[4:0]` have no effect.
- R4: An accepted call (`call_i`) pushes the current fetch address onto the stack. It then loads `{page bits, 0, imm_i[7:0]}`, so address bit 8 is always 0 after a call.
- R5: An accepted return (`ret_i`) loads the top stack entry into the counter. One cycle later, `w_wr_o` is high for exactly one cycle with `w_data_o = imm_i[7:0]`.
- R6: The stack holds two entries. A third call with no return in between discards the oldest entry, and the next two returns give back the two most recent addresses.
- R7: A return from an empty stack gives back the last remaining entry again, with no error indication. Before any call, that entry is 0.
- R8: An accepted low-byte write (`pcl_wr_i`) loads `{page bits, 0, pcl_wdata_i}`.
- R9: `pcl_rdata_o` always equals bits 7..0 of the fetch address.
- R10: `flush_o` is high for exactly the one cycle after an accepted jump, call, return or low-byte write. In that cycle all strobes are ignored and the counter steps by one.
- R11: When several strobes are asserted together, only one is accepted. The priority is jump, then call, then return, then low-byte write.
- R12: Stepping from the all-ones address wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| goto_i | input | 1 | Jump strobe |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Return-with-literal strobe |
| pcl_wr_i | input | 1 | Write strobe for the counter low byte |
| imm_i | input | 9 | Immediate field of the instruction |
| stat_i | input | 8 | Status register; page select in bits 6..5 |
| pcl_wdata_i | input | 8 | Data for a low-byte write |
| fetch_addr_o | output | PC_W | Program memory fetch address |
| pcl_rdata_o | output | 8 | Low byte of the counter, for register reads |
| flush_o | output | 1 | Discard the prefetched instruction |
| w_wr_o | output | 1 | Working-register write from a return |
| w_data_o | output | 8 | Literal delivered by a return |

## Verification
The hardest conditions to reach from the ports involve the stack's hidden depth: a return after an overflow has silently dropped an entry, and repeated returns from an empty stack. Strobes that arrive in a flush cycle, where they must be ignored, are also hard to reach. Directed sequences reach these cases with three nested calls followed by four returns, and with strobes held high through the cycle after a branch. A long run of mixed strobes, occasional resets and page values that include the ignored status bit then checks every cycle against a behavioural model. The model keeps the return addresses in a queue of at most two entries.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    localparam int IMM_W     = 9;
    localparam int LOW_W     = 8;
    localparam int PAGE_LSB  = 5;
    localparam int STK_DEPTH = 2;

    typedef enum logic [2:0] {
        ACT_SEQ,
        ACT_GOTO,
        ACT_CALL,
        ACT_RET,
        ACT_PCL
    } act_e;

    typedef struct packed {
        logic go;
        logic call;
        logic ret;
        logic pclw;
    } strobe_t;

    // Fixed priority; everything is squashed during a flush cycle.
    function automatic act_e pick_act(input logic squash, input strobe_t s);
        act_e a;
        a = ACT_SEQ;
        if (!squash) begin
            if (s.go)        a = ACT_GOTO;
            else if (s.call) a = ACT_CALL;
            else if (s.ret)  a = ACT_RET;
            else if (s.pclw) a = ACT_PCL;
        end
        return a;
    endfunction

    function automatic logic is_branch(input act_e a);
        return a != ACT_SEQ;
    endfunction

endpackage

// File: rtl/ppc_decode.sv
module ppc_decode
    import ppc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          strb,
    input  logic [LOW_W-1:0] lit,
    output act_e             act,
    output logic             flush_q,
    output logic             w_wr_q,
    output logic [LOW_W-1:0] w_data_q
);

    assign act = pick_act(flush_q, strb);

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_q  <= 1'b0;
            w_wr_q   <= 1'b0;
            w_data_q <= '0;
        end else begin
            flush_q <= is_branch(act);
            w_wr_q  <= (act == ACT_RET);
            if (act == ACT_RET) begin
                w_data_q <= lit;
            end
        end
    end

    // R10: a flush never lasts two cycles, and its cycle produces no literal write.
    p_flush_single_r10: assert property (@(posedge clk) disable iff (rst)
        flush_q |=> (!flush_q && !w_wr_q));

    // R5: the literal write is a single-cycle pulse.
    p_wwr_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        w_wr_q |=> !w_wr_q);

endmodule

// File: rtl/ppc_stack.sv
module ppc_stack
    import ppc_pkg::*;
#(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);

    logic [W-1:0] lvl_q [STK_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STK_DEPTH; i++) begin
                lvl_q[i] <= '0;
            end
        end else if (push) begin
            lvl_q[0] <= din;
            for (int i = 1; i < STK_DEPTH; i++) begin
                lvl_q[i] <= lvl_q[i-1];
            end
        end else if (pop) begin
            // The deepest level keeps its value, so an empty pop repeats it.
            for (int i = 0; i < STK_DEPTH - 1; i++) begin
                lvl_q[i] <= lvl_q[i+1];
            end
        end
    end

    assign top = lvl_q[0];

    // R4: a push places the return address on top.
    p_push_top_r4: assert property (@(posedge clk) disable iff (rst)
        push |=> (lvl_q[0] == $past(din)));

    // R6: a push moves the old top down and drops the deepest entry.
    p_push_shift_r6: assert property (@(posedge clk) disable iff (rst)
        push |=> (lvl_q[STK_DEPTH-1] == $past(lvl_q[STK_DEPTH-2])));

    // R7: a pop keeps the deepest entry, so an underflow repeats it.
    p_pop_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (lvl_q[STK_DEPTH-1] == $past(lvl_q[STK_DEPTH-1])
                            && lvl_q[0] == $past(lvl_q[1])));

endmodule

// File: rtl/ppc_target.sv
module ppc_target
    import ppc_pkg::*;
#(
    parameter int PC_W = 11
) (
    input  act_e             act,
    input  logic [PC_W-1:0]  pc_q,
    input  logic [IMM_W-1:0] imm,
    input  logic [7:0]       stat,
    input  logic [LOW_W-1:0] pcl_wdata,
    input  logic [PC_W-1:0]  stack_top,
    output logic [PC_W-1:0]  pc_d
);

    localparam int PG_W = PC_W - IMM_W;

    logic [PC_W-1:0] goto_t;
    logic [PC_W-1:0] call_t;
    logic [PC_W-1:0] pcl_t;
    logic            unused_stat;

    assign unused_stat = ^stat;

    generate
        if (PG_W > 0) begin : g_paged
            logic [PG_W-1:0] pg;
            assign pg     = stat[PAGE_LSB +: PG_W];
            assign goto_t = {pg, imm};
            assign call_t = {pg, 1'b0, imm[LOW_W-1:0]};
            assign pcl_t  = {pg, 1'b0, pcl_wdata};
        end else begin : g_flat
            assign goto_t = imm;
            assign call_t = {1'b0, imm[LOW_W-1:0]};
            assign pcl_t  = {1'b0, pcl_wdata};
        end
    endgenerate

    always_comb begin
        unique case (act)
            ACT_GOTO: pc_d = goto_t;
            ACT_CALL: pc_d = call_t;
            ACT_RET:  pc_d = stack_top;
            ACT_PCL:  pc_d = pcl_t;
            default:  pc_d = pc_q + 1'b1;
        endcase
    end

endmodule

// File: rtl/paged_pc.sv
module paged_pc
    import ppc_pkg::*;
#(
    parameter int PC_W = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            goto_i,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            pcl_wr_i,
    input  logic [8:0]      imm_i,
    input  logic [7:0]      stat_i,
    input  logic [7:0]      pcl_wdata_i,
    output logic [PC_W-1:0] fetch_addr_o,
    output logic [7:0]      pcl_rdata_o,
    output logic            flush_o,
    output logic            w_wr_o,
    output logic [7:0]      w_data_o
);

    strobe_t         strb;
    act_e            act;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] stack_top;

    assign strb = '{go: goto_i, call: call_i, ret: ret_i, pclw: pcl_wr_i};

    ppc_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .strb     (strb),
        .lit      (imm_i[LOW_W-1:0]),
        .act      (act),
        .flush_q  (flush_o),
        .w_wr_q   (w_wr_o),
        .w_data_q (w_data_o)
    );

    ppc_stack #(.W(PC_W)) u_stack (
        .clk  (clk),
        .rst  (rst),
        .push (act == ACT_CALL),
        .pop  (act == ACT_RET),
        .din  (pc_q),
        .top  (stack_top)
    );

    ppc_target #(.PC_W(PC_W)) u_target (
        .act       (act),
        .pc_q      (pc_q),
        .imm       (imm_i),
        .stat      (stat_i),
        .pcl_wdata (pcl_wdata_i),
        .stack_top (stack_top),
        .pc_d      (pc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '1;
        else     pc_q <= pc_d;
    end

    assign fetch_addr_o = pc_q;
    assign pcl_rdata_o  = pc_q[7:0];

    // R2: no accepted strobe means a plain step by one.
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_SEQ) |=> (fetch_addr_o == PC_W'($past(fetch_addr_o) + 1'b1)));

    // R10: an accepted jump raises the flush.
    p_goto_flush_r10: assert property (@(posedge clk) disable iff (rst)
        (goto_i && !flush_o) |=> flush_o);

    // R3: the low nine bits of a jump come from the immediate field.
    p_goto_low_r3: assert property (@(posedge clk) disable iff (rst)
        (goto_i && !flush_o) |=> (fetch_addr_o[8:0] == $past(imm_i)));

    // R4: call targets keep bit 8 clear.
    p_call_bit8_r4: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_CALL) |=> (!fetch_addr_o[8] && fetch_addr_o[7:0] == $past(imm_i[7:0])));

    // R5: a return delivers its literal one cycle later.
    p_ret_lit_r5: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_RET) |=> (w_wr_o && w_data_o == $past(imm_i[7:0])));

    // R8: a low-byte write lands in bits 7..0.
    p_pcl_low_r8: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_PCL) |=> (fetch_addr_o[7:0] == $past(pcl_wdata_i) && !fetch_addr_o[8]));

endmodule

// File: tb/paged_pc_tb_top.sv
`timescale 1ns/1ps
module paged_pc_tb_top;

    localparam int PC_W = 11;
    localparam int MASK = (1 << PC_W) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            goto_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, pcl_wr_i = 1'b0;
    logic [8:0]      imm_i = '0;
    logic [7:0]      stat_i = '0;
    logic [7:0]      pcl_wdata_i = '0;
    logic [PC_W-1:0] fetch_addr_o;
    logic [7:0]      pcl_rdata_o;
    logic            flush_o;
    logic            w_wr_o;
    logic [7:0]      w_data_o;

    always #2.5 clk = ~clk;

    paged_pc #(.PC_W(PC_W)) dut_i (
        .clk(clk), .rst(rst), .goto_i(goto_i), .call_i(call_i), .ret_i(ret_i),
        .pcl_wr_i(pcl_wr_i), .imm_i(imm_i), .stat_i(stat_i), .pcl_wdata_i(pcl_wdata_i),
        .fetch_addr_o(fetch_addr_o), .pcl_rdata_o(pcl_rdata_o), .flush_o(flush_o),
        .w_wr_o(w_wr_o), .w_data_o(w_data_o)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    int    mpc    = MASK;
    bit    mfl    = 0;
    bit    mwr    = 0;
    int    mwd    = 0;
    int    stk[$];
    string tag    = "R1";

    task automatic chk(input bit ok, input string t, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", t, got, exp);
        end
    endtask

    task automatic cyc(input bit r, input bit g, input bit c, input bit rt, input bit p,
                       input int imm, input int st, input int dat);
        int n;
        int pg;
        rst = r; goto_i = g; call_i = c; ret_i = rt; pcl_wr_i = p;
        imm_i = 9'(imm); stat_i = 8'(st); pcl_wdata_i = 8'(dat);
        @(posedge clk);
        n  = int'(g) + int'(c) + int'(rt) + int'(p);
        pg = (st >> 5) & 7;
        if (r) begin
            mpc = MASK; mfl = 0; mwr = 0; mwd = 0;
            stk.delete(); stk.push_back(0);
            tag = "R1";
        end else if (mfl) begin
            mpc = (mpc + 1) & MASK; mfl = 0; mwr = 0;
            tag = (n > 0) ? "R10" : "R2";
        end else begin
            mwr = 0;
            if (g) begin
                mpc = ((pg << 9) | (imm & 511)) & MASK; mfl = 1; tag = "R3";
            end else if (c) begin
                tag = (stk.size() == 2) ? "R6" : "R4";
                stk.push_front(mpc);
                if (stk.size() > 2) void'(stk.pop_back());
                mpc = ((pg << 9) | (imm & 255)) & MASK; mfl = 1;
            end else if (rt) begin
                tag = (stk.size() == 1) ? "R7" : "R5";
                mpc = stk[0];
                if (stk.size() > 1) void'(stk.pop_front());
                mwr = 1; mwd = imm & 255; mfl = 1;
            end else if (p) begin
                mpc = ((pg << 9) | (dat & 255)) & MASK; mfl = 1; tag = "R8";
            end else begin
                tag = (mpc == MASK) ? "R12" : "R2";
                mpc = (mpc + 1) & MASK;
            end
            if (n > 1) tag = "R11";
        end
        @(negedge clk);
        chk(int'(fetch_addr_o) == mpc, tag, int'(fetch_addr_o), mpc);
        chk(int'(pcl_rdata_o) == (mpc & 255), "R9", int'(pcl_rdata_o), mpc & 255);
        chk(flush_o == mfl, "R10 flush", int'(flush_o), int'(mfl));
        chk(w_wr_o == mwr, "R5 wr", int'(w_wr_o), int'(mwr));
        if (mwr) chk(int'(w_data_o) == mwd, "R5 data", int'(w_data_o), mwd);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        // R1 reset vector, then R12 wrap to zero
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 1, 1, 1, 1, 9'h1FF, 8'hFF, 8'hFF);
        idle(4);
        // R7 return from an empty stack gives 0
        cyc(0, 0, 0, 1, 0, 9'h05A, 0, 0);
        idle(1);
        // R3 jump with bit 7 set and page 01; R10 strobes held during the flush
        cyc(0, 1, 0, 0, 0, 9'h1A5, 8'hA0, 0);
        cyc(0, 1, 1, 1, 1, 9'h033, 8'hE0, 8'h11);
        idle(2);
        // R3 jump to page 11
        cyc(0, 1, 0, 0, 0, 9'h0F0, 8'h60, 0);
        idle(1);
        // R4 R6 three nested calls, then four returns (R5, R7)
        cyc(0, 0, 1, 0, 0, 9'h1FF, 8'h40, 0); idle(2);
        cyc(0, 0, 1, 0, 0, 9'h012, 8'h20, 0); idle(2);
        cyc(0, 0, 1, 0, 0, 9'h134, 8'h00, 0); idle(2);
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 0, 1, 0, 9'h0C0 + i, 0, 0);
            idle(1);
        end
        // R8 low-byte write with page 10, R9 read back
        cyc(0, 0, 0, 0, 1, 0, 8'h5F, 8'h9C);
        idle(3);
        // R11 priority combinations
        cyc(0, 0, 1, 1, 1, 9'h077, 8'h20, 8'h44); idle(1);
        cyc(0, 0, 0, 1, 1, 9'h088, 8'h20, 8'h44); idle(1);
        cyc(0, 1, 0, 0, 1, 9'h0AA, 8'h00, 8'h44); idle(1);
        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int sel;
            sel = int'($urandom % 10);
            cyc(($urandom % 97) == 0,
                sel == 0 || (sel == 4 && $urandom % 2 == 1),
                sel == 1 || (sel == 4 && $urandom % 2 == 1),
                sel == 2 || (sel == 4 && $urandom % 2 == 1),
                sel == 3 || (sel == 4 && $urandom % 2 == 1),
                int'($urandom % 512), int'($urandom % 256), int'($urandom % 256));
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule